// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that completes one 32-bit instruction in every clock cycle. On each rising edge it fetches the word addressed by the program counter, decodes it, reads two source registers, runs the ALU and then commits the result. The result goes to the register file, to the data memory, or to the program counter, depending on the instruction. Nine instructions are decoded: five register-to-register ALU operations (add, subtract, and, or, signed set-less-than), a word load, a word store, a branch taken when two registers are equal, and an absolute jump inside the current 256 MB region.

The instruction and data memories are internal and word-indexed. The index is taken from the low address bits above the byte offset, so both depths must be powers of two. The core runs whatever program has been written into the instruction memory. Its only outputs are debug outputs: the current program counter, and the register-write bus (enable, destination, data) for the instruction now executing. An environment uses this bus to follow architectural progress cycle by cycle.

Top module: `cpu_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears all 32 registers. The PC is 0 on the first clock after reset.
- R2: R-type instructions (opcode 0x00) apply the operation chosen by funct to registers rs (bits 25-21) and rt (bits 20-16), and write the result to rd (bits 15-11). The funct codes are add 0x20, subtract 0x22, and 0x24, or 0x25.
- R3: Set-less-than (funct 0x2A) writes 1 when rs is less than rt as signed 32-bit numbers, and writes 0 otherwise.
- R4: A load (opcode 0x23) adds the sign-extended bits 15-0 to rs. It writes the data-memory word selected by that address to rt.
- R5: A store (opcode 0x2B) writes rt to the data-memory word at rs plus the sign-extended offset. It does not write any register (write enable low).
- R6: A branch-if-equal (opcode 0x04) with rs equal to rt sets the PC to PC+4 plus the sign-extended offset times four. Otherwise the PC becomes PC+4.
- R7: A jump (opcode 0x02) sets the PC to the top four bits of PC+4 followed by bits 25-0 and two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it has no effect on later reads.
- R9: Any other opcode executes as a no-op. It writes neither a register nor memory, and the PC advances by 4.
- R10: Every instruction that is neither a taken branch nor a jump advances the PC by 4.
- R11: Loads and stores compute their address with an ALU add. Branch-if-equal compares with an ALU subtract and tests the zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pcOut | output | 32 | Address of the instruction now executing |
| wbEn | output | 1 | Register write enable of the current instruction |
| wbAddr | output | 5 | Destination register of the current instruction |
| wbData | output | 32 | Data to be written to the destination register |

## Verification
The bench builds the core with its default 64-word instruction and data memories. At that depth, a negative load offset and a jump index in the same region fall inside real words, and the program runs to its halt loop with headroom. A behavioural model steps the same program and compares PC and write bus every cycle. The program covers signed operands with mixed signs, a write to register 0, branches taken and not taken, a store that is read back, an unsupported opcode and a jump, each landing inside the 64-word range.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    ALU_AND = 2'b00,
    ALU_OR  = 2'b01,
    ALU_ADD = 2'b10,
    ALU_SLT = 2'b11
  } aluSel_e;

  typedef enum logic [1:0] {
    AOP_MEM   = 2'b00,
    AOP_BEQ   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluOp_e;

  typedef struct packed {
    logic    regDst;
    logic    aluSrc;
    logic    memToReg;
    logic    regWrite;
    logic    memWrite;
    logic    branch;
    logic    jump;
    aluOp_e  aluOp;
    logic    bNeg;
    aluSel_e aluSel;
  } ctrl_t;

endpackage

// File: rtl/cpu_alu_dec.sv
module cpu_alu_dec
  import cpu_pkg::*;
(
  input  aluOp_e     aluOp,
  input  logic [5:0] funct,
  output logic       bNeg,
  output aluSel_e    aluSel
);

  always_comb begin
    bNeg   = 1'b0;
    aluSel = ALU_ADD;
    case (aluOp)
      AOP_MEM: begin
        bNeg   = 1'b0;
        aluSel = ALU_ADD;
      end
      AOP_BEQ: begin
        bNeg   = 1'b1;
        aluSel = ALU_ADD;
      end
      AOP_FUNCT: begin
        case (funct)
          FN_SUB: begin bNeg = 1'b1; aluSel = ALU_ADD; end
          FN_AND: begin bNeg = 1'b0; aluSel = ALU_AND; end
          FN_OR:  begin bNeg = 1'b0; aluSel = ALU_OR;  end
          FN_SLT: begin bNeg = 1'b1; aluSel = ALU_SLT; end
          default: begin bNeg = 1'b0; aluSel = ALU_ADD; end
        endcase
      end
      default: begin
        bNeg   = 1'b0;
        aluSel = ALU_ADD;
      end
    endcase
  end

endmodule

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  ctrl_t   ctlMain;
  logic    bNegW;
  aluSel_e aluSelW;

  always_comb begin
    ctlMain = '0;
    ctlMain.aluOp = AOP_MEM;
    case (opcode)
      OP_RTYPE: begin
        ctlMain.regDst   = 1'b1;
        ctlMain.regWrite = 1'b1;
        ctlMain.aluOp    = AOP_FUNCT;
      end
      OP_LOAD: begin
        ctlMain.aluSrc   = 1'b1;
        ctlMain.memToReg = 1'b1;
        ctlMain.regWrite = 1'b1;
        ctlMain.aluOp    = AOP_MEM;
      end
      OP_STORE: begin
        ctlMain.aluSrc   = 1'b1;
        ctlMain.memWrite = 1'b1;
        ctlMain.aluOp    = AOP_MEM;
      end
      OP_BEQ: begin
        ctlMain.branch = 1'b1;
        ctlMain.aluOp  = AOP_BEQ;
      end
      OP_JUMP: begin
        ctlMain.jump = 1'b1;
      end
      default: ctlMain = '0;
    endcase
  end

  cpu_alu_dec u_aluDec (
    .aluOp  (ctlMain.aluOp),
    .funct  (funct),
    .bNeg   (bNegW),
    .aluSel (aluSelW)
  );

  always_comb begin
    ctl        = ctlMain;
    ctl.bNeg   = bNegW;
    ctl.aluSel = aluSelW;
  end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         bNeg,
  input  aluSel_e      aluSel,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] bEff;
  logic [W-1:0] sum;
  logic         ovf;
  logic         lessThan;

  assign bEff     = bNeg ? ~b : b;
  assign sum      = a + bEff + {{(W-1){1'b0}}, bNeg};
  assign ovf      = (a[W-1] == bEff[W-1]) && (sum[W-1] != a[W-1]);
  assign lessThan = sum[W-1] ^ ovf;

  always_comb begin
    case (aluSel)
      ALU_AND: y = a & bEff;
      ALU_OR:  y = a | bEff;
      ALU_ADD: y = sum;
      ALU_SLT: y = {{(W-1){1'b0}}, lessThan};
      default: y = sum;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrl_t       ctl,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic [31:0] pcOut,
  output logic        wbEn,
  output logic [4:0]  wbAddr,
  output logic [31:0] wbData
);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) dmem[i] = '0;
  end

  logic [31:0] pc, pcNext, pcPlus4, brTarget, jTarget;
  logic [31:0] instr, immExt;
  logic [4:0]  rs, rt, rd, wrAddr;
  logic [25:0] jIdx;
  logic [31:0] rdA, rdB, aluB, aluY, memRd, wrData;
  logic        aluZero, takeBranch;

  assign instr  = imem[pc[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign jIdx   = instr[25:0];
  assign immExt = {{16{instr[15]}}, instr[15:0]};

  cpu_regfile #(.W(32), .DEPTH(32)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rs),
    .rdAddrB (rt),
    .rdDataA (rdA),
    .rdDataB (rdB),
    .wrEn    (ctl.regWrite),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  assign aluB = ctl.aluSrc ? immExt : rdB;

  cpu_alu #(.W(32)) u_alu (
    .a      (rdA),
    .b      (aluB),
    .bNeg   (ctl.bNeg),
    .aluSel (ctl.aluSel),
    .y      (aluY),
    .zero   (aluZero)
  );

  assign memRd  = dmem[aluY[DAW+1:2]];
  assign wrData = ctl.memToReg ? memRd : aluY;
  assign wrAddr = ctl.regDst ? rd : rt;

  always_ff @(posedge clk) begin
    if (ctl.memWrite) dmem[aluY[DAW+1:2]] <= rdB;
  end

  assign pcPlus4    = pc + 32'd4;
  assign brTarget   = pcPlus4 + {immExt[29:0], 2'b00};
  assign jTarget    = {pcPlus4[31:28], jIdx, 2'b00};
  assign takeBranch = ctl.branch & aluZero;

  always_comb begin
    if (ctl.jump)        pcNext = jTarget;
    else if (takeBranch) pcNext = brTarget;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign pcOut  = pc;
  assign wbEn   = ctl.regWrite;
  assign wbAddr = wrAddr;
  assign wbData = wrData;

  // R1
  rst_pc_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !(ctl.branch && aluZero)) |=> pc == $past(pc) + 32'd4);

  // R6
  beq_target_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && !ctl.jump && rdA == rdB) |=>
      pc == $past(pc) + 32'd4 + ($past(immExt) << 2));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> pc == {$past(pc[31:28] + {3'b000, &$past(pc[27:2])}), $past(instr[25:0]), 2'b00});

  // R5
  store_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.memWrite |-> !ctl.regWrite);

  // R11
  mem_add_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.aluOp == AOP_MEM && (ctl.memWrite || ctl.memToReg)) |->
      (!ctl.bNeg && ctl.aluSel == ALU_ADD));

  // R11
  beq_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.aluOp == AOP_BEQ) |-> (ctl.bNeg && ctl.aluSel == ALU_ADD));

  // R10
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pcOut,
  output logic        wbEn,
  output logic [4:0]  wbAddr,
  output logic [31:0] wbData
);

  ctrl_t      ctl;
  logic [5:0] opcode;
  logic [5:0] funct;

  cpu_control u_ctl (
    .opcode (opcode),
    .funct  (funct),
    .ctl    (ctl)
  );

  cpu_datapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .opcode (opcode),
    .funct  (funct),
    .pcOut  (pcOut),
    .wbEn   (wbEn),
    .wbAddr (wbAddr),
    .wbData (wbData)
  );

endmodule

// File: tb/sim_cpu_core.sv
`timescale 1ns/1ps
module sim_cpu_core;

  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pcOut;
  logic        wbEn;
  logic [4:0]  wbAddr;
  logic [31:0] wbData;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cpu_core #(.IMEM_WORDS(WORDS), .DMEM_WORDS(WORDS)) u0 (
    .clk    (clk),
    .rst    (rst),
    .pcOut  (pcOut),
    .wbEn   (wbEn),
    .wbAddr (wbAddr),
    .wbData (wbData)
  );

  logic [31:0] prog  [WORDS];
  logic [31:0] mmem  [WORDS];
  logic [31:0] mreg  [32];
  logic [31:0] mpc;

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin prog[i] = 32'h0; mmem[i] = 32'h0; end
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    mmem[0] = 32'd5;
    mmem[1] = 32'hFFFF_FFFD;
    mmem[2] = 32'h1234_5678;
    prog[0]  = encI(6'h23, 0, 1, 16'd0);        // lw  r1,0(r0)
    prog[1]  = encI(6'h23, 0, 2, 16'd4);        // lw  r2,4(r0)
    prog[2]  = encR(1, 2, 3, 6'h20);            // add r3
    prog[3]  = encR(1, 2, 4, 6'h22);            // sub r4
    prog[4]  = encR(1, 2, 5, 6'h24);            // and r5
    prog[5]  = encR(1, 2, 6, 6'h25);            // or  r6
    prog[6]  = encR(2, 1, 7, 6'h2A);            // slt r7 = -3<5
    prog[7]  = encR(1, 2, 8, 6'h2A);            // slt r8 = 5<-3
    prog[8]  = encI(6'h2B, 0, 3, 16'd16);       // sw  r3,16(r0)
    prog[9]  = encI(6'h23, 0, 9, 16'd16);       // lw  r9,16(r0)
    prog[10] = encR(1, 1, 0, 6'h20);            // add r0 (ignored)
    prog[11] = encR(0, 1, 10, 6'h20);           // add r10,r0,r1
    prog[12] = encI(6'h04, 1, 9, 16'd2);        // beq not taken
    prog[13] = encI(6'h04, 9, 3, 16'd2);        // beq taken -> 16
    prog[14] = encR(1, 1, 11, 6'h20);
    prog[15] = encR(1, 1, 11, 6'h20);
    prog[16] = encI(6'h23, 4, 12, 16'hFFFC);    // lw r12,-4(r4)
    prog[17] = 32'hFC00_0000;                   // unsupported opcode
    prog[18] = {6'h02, 26'd20};                 // j 20
    prog[19] = encR(1, 1, 15, 6'h20);
    prog[20] = encI(6'h04, 0, 0, 16'hFFFF);     // self loop
    #1;
    for (int i = 0; i < WORDS; i++) begin
      u0.u_dp.imem[i] = prog[i];
      u0.u_dp.dmem[i] = mmem[i];
    end
  end

  initial begin
    string tag, pcTag;
    logic [31:0] ins, a, b, imm, res, nextPc, addr;
    logic [5:0]  op, fn;
    logic        expEn;
    logic [4:0]  expAddr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: PC cleared by reset
    check(pcOut == 32'h0, "R1", "pc in reset", pcOut, 32'h0);
    rst = 1'b0;
    mpc = 32'h0;
    pcTag = "R1";
    for (int cyc = 0; cyc < 40; cyc++) begin
      ins  = prog[(mpc >> 2) % WORDS];
      op   = ins[31:26];
      fn   = ins[5:0];
      a    = mreg[ins[25:21]];
      b    = mreg[ins[20:16]];
      imm  = {{16{ins[15]}}, ins[15:0]};
      nextPc = mpc + 4;
      expEn = 1'b0; expAddr = ins[20:16]; res = 32'h0; tag = "R9";
      check(pcOut == mpc, pcTag, "pc", pcOut, mpc);
      pcTag = "R10";
      case (op)
        6'h00: begin
          expEn = 1'b1; expAddr = ins[15:11]; tag = "R2";
          case (fn)
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
            default: res = a + b;
          endcase
          if (expAddr == 5'd0) tag = "R8";
        end
        6'h23: begin
          addr = a + imm; res = mmem[(addr >> 2) % WORDS];
          expEn = 1'b1; tag = "R4/R11";
        end
        6'h2B: begin
          addr = a + imm; mmem[(addr >> 2) % WORDS] = b; tag = "R5/R11";
        end
        6'h04: begin
          tag = "R6/R11"; pcTag = "R6";
          if (a == b) nextPc = mpc + 4 + (imm << 2);
        end
        6'h02: begin
          tag = "R7"; pcTag = "R7";
          nextPc = {nextPc[31:28], ins[25:0], 2'b00};
        end
        default: tag = "R9";
      endcase
      check(wbEn == expEn, tag, "wbEn", {31'h0, wbEn}, {31'h0, expEn});
      if (expEn) begin
        check(wbAddr == expAddr, tag, "wbAddr", {27'h0, wbAddr}, {27'h0, expAddr});
        check(wbData == res, tag, "wbData", wbData, res);
        if (expAddr != 5'd0) mreg[expAddr] = res;
      end
      mpc = nextPc;
      @(negedge clk);
    end
    // R8: r0 stayed zero, so r10 = r0 + r1 = 5 was checked on the write bus
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule